// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Synchronous Clock Output

This block turns parallel words into NRZ asynchronous frames on a single serial data line. The frame format is fixed: one low start bit, a word of 8 or 9 bits sent least significant bit first, then one high stop bit. The caller writes a word into a one-entry holding register. The word moves into a shift register at the next frame boundary, so a second word can wait while the first one is still being sent. When parity is on, the block replaces the top bit of the word with a computed even or odd parity bit. A separate command sends a line break: the line stays low for a long fixed run of bit times, then returns high for one bit time.

Bit timing comes from an external tick pulse that arrives twice per bit time. The first tick of a pair starts a bit and the second marks its midpoint. That midpoint lets the block drive an optional synchronous clock for external shift-register peripherals. The clock pulses once in each data bit and never during a start bit or a stop bit. The polarity and the half of the bit that holds the pulse are both selectable, and so is whether the last data bit gets a pulse. Two status outputs report whether the holding register is empty and whether all transmission has finished.

Top module: `sertx_core`

## Requirements
- R1: A frame is one low start bit, then the word sent least significant bit first, then one high stop bit. The word is 9 bits when cfg_nine is 1 and 8 bits (wr_data[7:0]) when cfg_nine is 0. Every bit lasts two baud_x2 ticks.
- R2: With cfg_par_en set, the top bit of the word (bit 8 in 9-bit mode, bit 7 in 8-bit mode) is replaced by a parity bit. With cfg_par_odd at 0 the word as sent has an even number of ones. With cfg_par_odd at 1 it has an odd number of ones.
- R3: While tx_en is 0, txd is 1, hold_empty is 1 from the next cycle on, and any write is discarded. While the block is enabled and has nothing to send, txd stays 1.
- R4: After tx_en rises, the line stays high for one full frame length (word length plus two bits) before the first start bit. In the cycle tx_en rises, txd is 1.
- R5: A write with tx_en at 1 makes hold_empty 0 on the next cycle. hold_empty returns to 1 when the word moves into the shift register. A word waiting in the holding register starts its start bit right after the previous stop bit, with no idle gap.
- R6: tx_done is 1 after reset. A write clears it on the next cycle, and so does the start of a break. It sets again at the end of a stop bit when nothing more is pending.
- R7: A pulse on brk_req drives txd low for 13 bit times, then high for one bit time. A break requested in the same cycle as a data write is sent before that data word.
- R8: With cfg_clk_en at 1, sclk gives one pulse per data bit and no pulse during start, stop or idle bits. The last data bit gets a pulse only when cfg_last_pulse is 1. With cfg_clk_en at 0, sclk rests at cfg_clk_pol.
- R9: sclk rests at cfg_clk_pol, and a pulse is the inverse level. With cfg_clk_pha at 0 the pulse fills the second half of the bit. With cfg_clk_pha at 1 it fills the first half.
- R10: After reset, txd is 1, hold_empty is 1, tx_done is 1 and sclk equals cfg_clk_pol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_x2 | input | 1 | One-cycle tick, two per bit time |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W+1 | Word to send (top bit used in 9-bit mode) |
| cfg_nine | input | 1 | Word length: 1 = 9 bits, 0 = 8 bits |
| cfg_par_en | input | 1 | Parity replaces the top word bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| brk_req | input | 1 | One-cycle request to send a break |
| cfg_clk_en | input | 1 | Enables the synchronous clock output |
| cfg_clk_pol | input | 1 | Rest level of sclk |
| cfg_clk_pha | input | 1 | 0 = pulse in second bit half, 1 = first half |
| cfg_last_pulse | input | 1 | Pulse sclk on the last data bit too |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Synchronous clock output |
| hold_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | No frame or break in progress and none pending |

## Verification
Most internal faults show up on txd within one frame. A wrong bit counter or a wrong shift gives the wrong word length or a stop bit in the wrong place. A bad parity term changes one bit. A slip in the bit-half phase moves every edge by half a bit, and the sclk samples taken in the first and second half of each bit catch that at once. Faults in the holding register or the boundary logic show up as an idle gap, or a missing word, between frames sent back to back. A fault in the break counter changes the low run length, which is measured to the cycle. Flag faults are visible within one cycle of a write, or at the end of the next stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_START,
      ST_DATA,
      ST_STOP,
      ST_BRK,
      ST_BRKSTOP
   } tx_state_t;

   typedef struct packed {
      logic nine;
      logic par_en;
      logic par_odd;
   } word_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [WORD_W-1:0] din,
   input  logic              take,
   output logic              full,
   output logic [WORD_W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (wr) begin
         full <= 1'b1;
         dout <= din;
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
   import sertx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BRK_BITS = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              tx_en,
   input  word_cfg_t         cfg,
   input  logic              hold_full,
   input  logic [DATA_W:0]   hold_data,
   input  logic              brk_req,
   input  logic              wr_acc,
   output logic              take,
   output logic              txd,
   output logic              data_act,
   output logic              last_bit,
   output logic              half,
   output logic              tx_done
);

   localparam int WORD_W    = DATA_W + 1;
   localparam int FRAME_MAX = WORD_W + 2;
   localparam int SEG_MAX   = (BRK_BITS > FRAME_MAX) ? BRK_BITS : FRAME_MAX;
   localparam int CNT_W     = $clog2(SEG_MAX + 1);

   tx_state_t         state;
   logic              en_q;
   logic              brk_pend;
   logic              ph_q;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg;

   logic [CNT_W-1:0]  nbits, frame_len, last_cnt;
   logic              seg_last, bit_end, at_bound, brk_go, go_idle;

   function automatic logic [WORD_W-1:0] shape(input logic [WORD_W-1:0] d,
                                               input word_cfg_t c);
      logic [WORD_W-1:0] w;
      w = d;
      if (!c.nine) w[WORD_W-1] = 1'b0;
      if (c.par_en) begin
         if (c.nine) w[WORD_W-1] = (^d[WORD_W-2:0]) ^ c.par_odd;
         else        w[WORD_W-2] = (^d[WORD_W-3:0]) ^ c.par_odd;
      end
      return w;
   endfunction

   always_comb begin
      nbits     = cfg.nine ? CNT_W'(WORD_W) : CNT_W'(WORD_W - 1);
      frame_len = nbits + CNT_W'(2);
      case (state)
         ST_PRE:  last_cnt = frame_len - CNT_W'(1);
         ST_DATA: last_cnt = nbits - CNT_W'(1);
         ST_BRK:  last_cnt = CNT_W'(BRK_BITS - 1);
         default: last_cnt = '0;
      endcase
      seg_last = (cnt == last_cnt);
      bit_end  = tick && ph_q && (state != ST_IDLE);
      at_bound = tx_en && en_q &&
                 ((state == ST_IDLE && tick) ||
                  (bit_end && seg_last &&
                   (state == ST_PRE || state == ST_STOP || state == ST_BRKSTOP)));
      brk_go   = at_bound && brk_pend;
      take     = at_bound && !brk_pend && hold_full;
      go_idle  = at_bound && !brk_pend && !hold_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         en_q     <= 1'b0;
         brk_pend <= 1'b0;
         ph_q     <= 1'b0;
         cnt      <= '0;
         shreg    <= '1;
      end else begin
         en_q <= tx_en;
         if (!tx_en) begin
            state    <= ST_IDLE;
            ph_q     <= 1'b0;
            cnt      <= '0;
            brk_pend <= 1'b0;
         end else if (!en_q) begin
            state    <= ST_PRE;
            ph_q     <= 1'b0;
            cnt      <= '0;
            brk_pend <= brk_req;
         end else begin
            if (at_bound) begin
               ph_q <= 1'b0;
               cnt  <= '0;
               if (brk_go) begin
                  state <= ST_BRK;
               end else if (take) begin
                  state <= ST_START;
                  shreg <= shape(hold_data, cfg);
               end else begin
                  state <= ST_IDLE;
               end
            end else if (bit_end) begin
               ph_q <= 1'b0;
               cnt  <= seg_last ? '0 : cnt + CNT_W'(1);
               case (state)
                  ST_START: state <= ST_DATA;
                  ST_DATA: begin
                     shreg <= {1'b1, shreg[WORD_W-1:1]};
                     if (seg_last) state <= ST_STOP;
                  end
                  ST_BRK: if (seg_last) state <= ST_BRKSTOP;
                  default: ;
               endcase
            end else if (tick && state != ST_IDLE) begin
               ph_q <= 1'b1;
            end
            if (brk_go)  brk_pend <= 1'b0;
            if (brk_req) brk_pend <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_done <= 1'b1;
      else if (!tx_en)  tx_done <= 1'b1;
      else if (wr_acc)  tx_done <= 1'b0;
      else if (brk_go)  tx_done <= 1'b0;
      else if (go_idle) tx_done <= 1'b1;
   end

   always_comb begin
      case (state)
         ST_START, ST_BRK: txd = 1'b0;
         ST_DATA:          txd = shreg[0];
         default:          txd = 1'b1;
      endcase
      if (!tx_en) txd = 1'b1;
   end

   assign data_act = (state == ST_DATA);
   assign last_bit = seg_last;
   assign half     = ph_q;

endmodule

// File: rtl/sertx_sclk.sv
module sertx_sclk #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic clk_en,
   input  logic pol,
   input  logic pha,
   input  logic last_pulse,
   input  logic data_act,
   input  logic last_bit,
   input  logic half,
   output logic sclk
);

   logic pulse, level;

   assign pulse = tx_en && clk_en && data_act && (!last_bit || last_pulse) && (half ^ pha);
   assign level = pol ^ pulse;

   generate
      if (OUT_REG) begin : g_reg
         logic sclk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sclk_q <= 1'b0;
            else        sclk_q <= level;
         end
         assign sclk = sclk_q;
      end else begin : g_comb
         assign sclk = level;
      end
   endgenerate

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BRK_BITS = 13,
   parameter bit SCLK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_x2,
   input  logic              tx_en,
   input  logic              wr_valid,
   input  logic [DATA_W:0]   wr_data,
   input  logic              cfg_nine,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              brk_req,
   input  logic              cfg_clk_en,
   input  logic              cfg_clk_pol,
   input  logic              cfg_clk_pha,
   input  logic              cfg_last_pulse,
   output logic              txd,
   output logic              sclk,
   output logic              hold_empty,
   output logic              tx_done
);

   localparam int WORD_W = DATA_W + 1;

   generate
      if (DATA_W < 4 || DATA_W > 16) begin : g_bad_width
         $error("sertx_core: DATA_W must lie in 4..16");
      end
      if (BRK_BITS < WORD_W + 2) begin : g_bad_brk
         $error("sertx_core: BRK_BITS must exceed one frame");
      end
   endgenerate

   word_cfg_t         cfg;
   logic              wr_acc, take, hold_full;
   logic [WORD_W-1:0] hold_data;
   logic              data_act, last_bit, half;

   assign cfg    = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};
   assign wr_acc = wr_valid && tx_en;

   sertx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!tx_en),
      .wr   (wr_acc),
      .din  (wr_data),
      .take (take),
      .full (hold_full),
      .dout (hold_data)
   );

   sertx_seq #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_x2),
      .tx_en    (tx_en),
      .cfg      (cfg),
      .hold_full(hold_full),
      .hold_data(hold_data),
      .brk_req  (brk_req && tx_en),
      .wr_acc   (wr_acc),
      .take     (take),
      .txd      (txd),
      .data_act (data_act),
      .last_bit (last_bit),
      .half     (half),
      .tx_done  (tx_done)
   );

   sertx_sclk #(.OUT_REG(SCLK_REG)) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .clk_en    (cfg_clk_en),
      .pol       (cfg_clk_pol),
      .pha       (cfg_clk_pha),
      .last_pulse(cfg_last_pulse),
      .data_act  (data_act),
      .last_bit  (last_bit),
      .half      (half),
      .sclk      (sclk)
   );

   assign hold_empty = !hold_full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_valid,
   input logic cfg_clk_en,
   input logic cfg_clk_pol,
   input logic txd,
   input logic sclk,
   input logic hold_empty,
   input logic tx_done
);

   AST_OFF_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> hold_empty);                                           // R3

   AST_EN_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !$past(tx_en)) |-> txd);                                // R4

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && wr_valid) |=> !hold_empty);                             // R5

   AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && wr_valid) |=> !tx_done);                                // R6

   AST_SCLK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_clk_en && $past(!cfg_clk_en) && $stable(cfg_clk_pol)) |-> (sclk == cfg_clk_pol)); // R8

endmodule

bind sertx_core sertx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .wr_valid   (wr_valid),
   .cfg_clk_en (cfg_clk_en),
   .cfg_clk_pol(cfg_clk_pol),
   .txd        (txd),
   .sclk       (sclk),
   .hold_empty (hold_empty),
   .tx_done    (tx_done)
);

// File: tb/tb_sertx_core.sv
`timescale 1ns/1ps
module tb_sertx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_x2 = 1'b0;
   logic       tx_en = 1'b0, wr_valid = 1'b0, brk_req = 1'b0;
   logic [8:0] wr_data = '0;
   logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_clk_en = 1'b0, cfg_clk_pol = 1'b0, cfg_clk_pha = 1'b0, cfg_last_pulse = 1'b0;
   logic       txd, sclk, hold_empty, tx_done;

   int nchk = 0, nfail = 0, cyc = 0;
   logic [1:0] divcnt = '0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc     <= cyc + 1;
      divcnt  <= divcnt + 2'd1;
      baud_x2 <= (divcnt == 2'd3);
   end

   sertx_core dut (
      .clk(clk), .rst_n(rst_n), .baud_x2(baud_x2), .tx_en(tx_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .cfg_nine(cfg_nine),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .brk_req(brk_req),
      .cfg_clk_en(cfg_clk_en), .cfg_clk_pol(cfg_clk_pol), .cfg_clk_pha(cfg_clk_pha),
      .cfg_last_pulse(cfg_last_pulse), .txd(txd), .sclk(sclk),
      .hold_empty(hold_empty), .tx_done(tx_done)
   );

   // fields: nine par odd clk_en pol pha last | data[9] | pad[3] | expected word[9]
   localparam int NV = 8;
   localparam logic [27:0] VEC [NV] = '{
      {7'b000_0000, 9'h0A5, 3'b0, 9'h0A5},
      {7'b100_1000, 9'h1C3, 3'b0, 9'h1C3},
      {7'b010_1101, 9'h007, 3'b0, 9'h087},
      {7'b011_1011, 9'h007, 3'b0, 9'h007},
      {7'b110_1110, 9'h0FF, 3'b0, 9'h0FF},
      {7'b111_0000, 9'h100, 3'b0, 9'h100},
      {7'b000_1001, 9'h100, 3'b0, 9'h000},
      {7'b010_0000, 9'h07F, 3'b0, 9'h0FF}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic write_word(input logic [8:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // Captures one frame; starts at the first negedge where txd is low.
   task automatic rx_frame(input int n, output logic [11:0] bits,
                           output logic [11:0] s1, output logic [11:0] s2,
                           output int t0, output bit tmo);
      int guard = 0;
      tmo  = 1'b0;
      bits = '0; s1 = '0; s2 = '0;
      while (txd !== 1'b0 && guard < 4000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 4000) tmo = 1'b1;
      t0 = cyc;
      for (int b = 0; b < n + 2; b++) begin
         repeat (2) @(negedge clk);
         s1[b] = sclk;
         repeat (2) @(negedge clk);
         bits[b] = txd;
         repeat (2) @(negedge clk);
         s2[b] = sclk;
         repeat (2) @(negedge clk);
      end
   endtask

   initial begin
      logic [11:0] bits, s1, s2, e1, e2;
      logic [8:0]  got;
      int          t0, tb0, tlow, nlow, n;
      bit          tmo;

      repeat (3) @(negedge clk);
      // R10: reset state
      check(txd == 1'b1,        "R10", "txd after reset", txd, 1);
      check(hold_empty == 1'b1, "R10", "hold_empty after reset", hold_empty, 1);
      check(tx_done == 1'b1,    "R10", "tx_done after reset", tx_done, 1);
      check(sclk == cfg_clk_pol,"R10", "sclk after reset", sclk, cfg_clk_pol);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4: idle frame before the first start bit after enabling
      tx_en = 1'b1;
      tb0 = cyc;
      write_word(9'h03C);
      check(hold_empty == 1'b0, "R5", "hold_empty after write", hold_empty, 0);
      check(tx_done == 1'b0,    "R6", "tx_done after write", tx_done, 0);
      rx_frame(8, bits, s1, s2, t0, tmo);
      check(!tmo && (t0 - tb0) >= 72 && (t0 - tb0) <= 96, "R4",
            "cycles from enable to start", t0 - tb0, 80);
      check(bits[8:1] == 8'h3C && bits[0] == 1'b0 && bits[9] == 1'b1, "R1",
            "first frame", bits[9:0], {1'b1, 8'h3C, 1'b0});

      // Vector table: R1, R2, R8, R9, R6
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         {cfg_nine, cfg_par_en, cfg_par_odd, cfg_clk_en, cfg_clk_pol, cfg_clk_pha, cfg_last_pulse}
            = VEC[v][27:21];
         n = cfg_nine ? 9 : 8;
         write_word(VEC[v][20:12]);
         rx_frame(n, bits, s1, s2, t0, tmo);
         got = '0;
         for (int i = 0; i < n; i++) got[i] = bits[i + 1];
         check(!tmo && bits[0] == 1'b0 && bits[n + 1] == 1'b1 && got == VEC[v][8:0],
               "R1/R2", $sformatf("vector %0d word", v), got, VEC[v][8:0]);
         e1 = '0; e2 = '0;
         for (int b = 0; b < n + 2; b++) begin
            logic act;
            act   = cfg_clk_en && b >= 1 && b <= n && (b < n || cfg_last_pulse);
            e1[b] = cfg_clk_pol ^ (act && cfg_clk_pha);
            e2[b] = cfg_clk_pol ^ (act && !cfg_clk_pha);
         end
         check(s1 == e1 && s2 == e2, "R8/R9", $sformatf("vector %0d sclk halves", v),
               {s1, 4'h0, s2}, {e1, 4'h0, e2});
         repeat (2) @(negedge clk);
         check(tx_done == 1'b1 && hold_empty == 1'b1, "R6",
               $sformatf("vector %0d done flags", v), {tx_done, hold_empty}, 2'b11);
      end

      // R5: queued word follows a stop bit directly
      @(negedge clk);
      {cfg_nine, cfg_par_en, cfg_par_odd, cfg_clk_en} = 4'b0000;
      write_word(9'h05A);
      fork
         rx_frame(8, bits, s1, s2, t0, tmo);
         begin
            while (!hold_empty) @(negedge clk);
            write_word(9'h0C3);
            check(hold_empty == 1'b0, "R5", "hold_empty after queued write", hold_empty, 0);
         end
      join
      check(bits[8:1] == 8'h5A, "R5", "first of pair", bits[8:1], 8'h5A);
      tb0 = t0;
      rx_frame(8, bits, s1, s2, t0, tmo);
      check(!tmo && (t0 - tb0) == 80, "R5", "gap between queued frames", t0 - tb0, 80);
      check(bits[8:1] == 8'hC3, "R5", "second of pair", bits[8:1], 8'hC3);
      repeat (10) @(negedge clk);

      // R7: break with a data word requested in the same cycle
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 9'h0FF; brk_req = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; brk_req = 1'b0;
      check(tx_done == 1'b0, "R6", "tx_done after break request", tx_done, 0);
      while (txd !== 1'b0) @(negedge clk);
      tlow = cyc; nlow = 0;
      while (txd === 1'b0 && nlow < 400) begin
         nlow++;
         @(negedge clk);
      end
      check(nlow == 104, "R7", "break low cycles", nlow, 104);
      rx_frame(8, bits, s1, s2, t0, tmo);
      check(!tmo && (t0 - tlow) == 112, "R7", "break then stop bit length", t0 - tlow, 112);
      check(bits[8:1] == 8'hFF, "R7", "data after break", bits[8:1], 8'hFF);

      // R3: idle line with nothing queued
      nlow = 0;
      repeat (40) begin
         @(negedge clk);
         if (txd !== 1'b1) nlow++;
      end
      check(nlow == 0, "R3", "idle low samples", nlow, 0);

      // R3: disabled transmitter ignores writes, sclk at rest
      @(negedge clk);
      tx_en = 1'b0; cfg_clk_en = 1'b1; cfg_clk_pol = 1'b1;
      write_word(9'h055);
      check(hold_empty == 1'b1, "R3", "hold_empty after write while off", hold_empty, 1);
      nlow = 0;
      repeat (40) begin
         @(negedge clk);
         if (txd !== 1'b1 || sclk !== 1'b1) nlow++;
      end
      check(nlow == 0, "R3", "line or sclk moved while off", nlow, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog (R1..): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule